// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target end of a two-wire serial EEPROM. Its address space is 64 KiB, split into 512 pages of 128 bytes. SCL and SDA come in already synchronised to the system clock. The block finds Start and Stop conditions on these lines and checks the device address byte against a fixed prefix and three strap inputs. It then takes a 16-bit word address in two bytes. The supported transfers are byte write, page write, random read, current-address read and sequential read. The block never drives SDA high. It only pulls the line low, through an output-enable pin that the pad turns into an open-drain pull-down.

Write data first goes into a 128-byte page buffer. The buffer is copied into the array only when a Stop closes the write, and only if the write-protect input is low at that moment. A copy starts a busy window of programmable length, which stands in for the self-timed programming cycle. While that window is open, the block does not acknowledge its own address, so a master can poll until the write finishes. The storage is a behavioural byte array. Its depth is a parameter that defaults to 1 KiB so the model elaborates quickly. Word addresses alias onto its low bits, and a depth of 16 address bits gives the full part.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The first byte after a Start is the device byte, sent MSB first. The block acknowledges it by pulling SDA low during the ninth clock only when bits 7..4 equal 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 = 1 selects a read and bit 0 = 0 selects a write.
- R2: A device byte that does not match is not acknowledged. After it, the block leaves SDA released and acknowledges nothing until the next Start.
- R3: SDA falling while SCL is high is a Start, and it restarts address decoding at any point, including the middle of a transfer (repeated Start). SDA rising while SCL is high is a Stop, and it returns the block to idle.
- R4: After a write-mode device byte, the next two bytes form the word address, high byte first, and each is acknowledged. A following data byte is acknowledged, and after the Stop a random read of that address returns it.
- R5: Read data is shifted out MSB first. SDA changes only after a falling SCL edge, and the master samples each bit while SCL is high.
- R6: A page write carries any number of data bytes, each acknowledged. After the Stop, every byte sits at consecutive addresses from the word address onward.
- R7: During a page write only the low 7 address bits advance, and they wrap inside the page. A byte sent after offset 127 lands at offset 0 of the same page.
- R8: When wp_i is high at the Stop, the array is left unchanged and no busy window starts, so the device byte is acknowledged at once.
- R9: A Stop that closes a write holding at least one data byte, with wp_i low, starts a busy window of WR_CYCLES clocks. During the window the device byte is not acknowledged. After the window it is acknowledged again.
- R10: In a read, the address counter advances after every byte sent. When the master acknowledges, the next byte comes from the advanced address, and the counter rolls over from 0xFFFF to 0x0000.
- R11: A read that ends with a master NACK and a Stop leaves the counter at the last address read plus one. A current-address read (a Start followed directly by a read-mode device byte) returns the byte at that address.
- R12: A Start that arrives before the Stop throws away any data bytes not yet committed. The array keeps its old contents and no busy window starts.
- R13: After reset, sda_oe_o is low and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock, synchronised |
| sda_i | input | 1 | Serial data line level, synchronised |
| strap_i | input | 3 | Device select straps compared with device byte bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The block reacts to an SCL falling edge one clock after it sees the edge, because the edge is detected in one register and the enable is updated in the next. The bench therefore changes SDA two clocks into the low phase and samples the line two clocks into the high phase, when the acknowledge or data bit has long settled. The busy window opens at the clock where the Stop is seen and lasts WR_CYCLES clocks. The bench polls once a single byte after the Stop, expecting a NACK. It then waits more than WR_CYCLES clocks and expects an ACK. Array contents are only ever checked through later read transfers at the ports.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int PAGE_AW = 7;
    localparam int PAGE_N  = 1 << PAGE_AW;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] s);
        return (b[7:4] == DEV_PREFIX) && (b[3:1] == s);
    endfunction

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise   = scl_i & ~scl_q;
    assign scl_fall   = ~scl_i & scl_q;
    assign cond_start = scl_i & scl_q & sda_q & ~sda_i;
    assign cond_stop  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (start)        cnt <= CW'(CYCLES);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R9: a commit always opens the busy window on the next cycle
    p_busy_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/eep_store.sv
module eep_store import eep_pkg::*; #(
    parameter int STORE_AW = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        buf_clear,
    input  logic                        buf_we,
    input  logic [PAGE_AW-1:0]          buf_idx,
    input  logic [7:0]                  buf_data,
    input  logic                        commit,
    input  logic [STORE_AW-PAGE_AW-1:0] page_sel,
    input  logic [STORE_AW-1:0]         rd_addr,
    output logic [7:0]                  rd_data
);
    localparam int DEPTH = 1 << STORE_AW;

    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [PAGE_N];
    logic [PAGE_N-1:0] pval;

    always_ff @(posedge clk) begin
        if (rst) begin
            pval <= '0;
            for (int i = 0; i < PAGE_N; i++) pbuf[i] <= 8'h00;
        end else if (buf_clear || commit) begin
            pval <= '0;
        end else if (buf_we) begin
            pbuf[buf_idx] <= buf_data;
            pval[buf_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_N; i++)
                if (pval[i]) mem[{page_sel, PAGE_AW'(i)}] <= pbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];

    // R6: a commit only ever happens with buffered bytes present
    p_commit_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        commit |-> (|pval));

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target import eep_pkg::*; #(
    parameter int ADDR_W    = 16,
    parameter int STORE_AW  = 10,
    parameter int WR_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    logic scl_rise, scl_fall, cond_start, cond_stop;
    logic busy, commit, buf_we;
    logic [7:0] rd_data;

    phase_e              phase, nxt;
    logic [3:0]          bitcnt;
    logic                in_ack, mack, oe_q, wr_any;
    logic [7:0]          shreg, tx, addr_hi;
    logic [ADDR_W-1:0]   addr_ctr;

    eep_bus_cond i_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .cond_start(cond_start), .cond_stop(cond_stop)
    );

    eep_wr_timer #(.CYCLES(WR_CYCLES)) i_timer (
        .clk(clk), .rst(rst), .start(commit), .busy(busy)
    );

    assign buf_we = (phase == PH_WR) && scl_fall && (bitcnt == 4'd8) && !in_ack;
    assign commit = cond_stop && wr_any && !wp_i && !busy;

    eep_store #(.STORE_AW(STORE_AW)) i_store (
        .clk(clk), .rst(rst),
        .buf_clear(cond_start),
        .buf_we(buf_we),
        .buf_idx(addr_ctr[PAGE_AW-1:0]),
        .buf_data(shreg),
        .commit(commit),
        .page_sel(addr_ctr[STORE_AW-1:PAGE_AW]),
        .rd_addr(addr_ctr[STORE_AW-1:0]),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            nxt      <= PH_IDLE;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            mack     <= 1'b0;
            oe_q     <= 1'b0;
            wr_any   <= 1'b0;
            shreg    <= '0;
            tx       <= '0;
            addr_hi  <= '0;
            addr_ctr <= '0;
        end else if (cond_start) begin
            phase  <= PH_DEV;
            bitcnt <= '0;
            in_ack <= 1'b0;
            oe_q   <= 1'b0;
            wr_any <= 1'b0;
        end else if (cond_stop) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            oe_q   <= 1'b0;
            wr_any <= 1'b0;
        end else if (phase == PH_RD) begin
            if (scl_rise) begin
                if (bitcnt < 4'd8)  bitcnt <= bitcnt + 1'b1;
                else if (in_ack)    mack   <= !sda_i;
            end else if (scl_fall) begin
                if (bitcnt != 4'd0 && bitcnt < 4'd8) begin
                    oe_q <= ~tx[3'(7 - bitcnt)];
                end else if (bitcnt == 4'd8 && !in_ack) begin
                    oe_q     <= 1'b0;
                    in_ack   <= 1'b1;
                    addr_ctr <= addr_ctr + 1'b1;
                end else if (in_ack) begin
                    in_ack <= 1'b0;
                    if (mack) begin
                        tx     <= rd_data;
                        oe_q   <= ~rd_data[7];
                        bitcnt <= '0;
                    end else begin
                        oe_q  <= 1'b0;
                        phase <= PH_IDLE;
                    end
                end
            end
        end else if (phase != PH_IDLE) begin
            if (scl_rise && bitcnt < 4'd8) begin
                shreg  <= {shreg[6:0], sda_i};
                bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8 && !in_ack) begin
                case (phase)
                    PH_DEV: begin
                        if (dev_match(shreg, strap_i) && !busy) begin
                            oe_q   <= 1'b1;
                            in_ack <= 1'b1;
                            nxt    <= shreg[0] ? PH_RD : PH_AHI;
                            if (shreg[0]) tx <= rd_data;
                        end else begin
                            oe_q  <= 1'b0;
                            phase <= PH_IDLE;
                        end
                    end
                    PH_AHI: begin
                        addr_hi <= shreg;
                        oe_q    <= 1'b1;
                        in_ack  <= 1'b1;
                        nxt     <= PH_ALO;
                    end
                    PH_ALO: begin
                        addr_ctr <= ADDR_W'({addr_hi, shreg});
                        oe_q     <= 1'b1;
                        in_ack   <= 1'b1;
                        nxt      <= PH_WR;
                    end
                    default: begin
                        addr_ctr <= {addr_ctr[ADDR_W-1:PAGE_AW],
                                     addr_ctr[PAGE_AW-1:0] + 1'b1};
                        wr_any   <= 1'b1;
                        oe_q     <= 1'b1;
                        in_ack   <= 1'b1;
                        nxt      <= PH_WR;
                    end
                endcase
            end else if (scl_fall && in_ack) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                phase  <= nxt;
                oe_q   <= (nxt == PH_RD) ? ~tx[7] : 1'b0;
            end
        end
    end

    assign sda_oe_o = oe_q;

    // R5: the line is only pulled low while SCL is low
    p_oe_rise_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> !scl_i);

    // R2: an idle target keeps SDA released
    p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !oe_q);

    // R3: a Start always restarts device byte decoding
    p_start_to_dev_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cond_start)) |-> (phase == PH_DEV));

    // R7: page write never leaves its page
    p_page_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR && $past(phase) == PH_WR) |-> $stable(addr_ctr[ADDR_W-1:PAGE_AW]));

    // R9: no device acknowledge during the busy window
    p_busy_nack_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEV && $rose(oe_q)) |-> !busy);

endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int WRC = 300;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int nchk = 0;
    int nfail = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_target #(.WR_CYCLES(WRC)) i_i2c_eeprom_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(2);
        scl = 1'b1;   tick(4);
        m_sda = 1'b0; tick(4);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(2);
        scl = 1'b1;   tick(4);
        m_sda = 1'b1; tick(4);
    endtask

    task automatic wbit(input logic b);
        m_sda = b;  tick(2);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(2);
    endtask

    task automatic rbit(output logic v);
        m_sda = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        v = sda_line; tick(2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(v);
        ack = !v;
    endtask

    task automatic recv(input logic master_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            rbit(v);
            b[i] = v;
        end
        wbit(!master_ack);
    endtask

    task automatic set_addr(input logic [15:0] a, input string req);
        logic ack;
        bus_start;
        send(DEVW, ack);     chk(req, 16'(ack), 16'd1);
        send(a[15:8], ack);  chk(req, 16'(ack), 16'd1);
        send(a[7:0], ack);   chk(req, 16'(ack), 16'd1);
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
        logic ack;
        set_addr(a, "R4");
        bus_start;
        send(DEVR, ack); chk("R3 repeated start read ack", 16'(ack), 16'd1);
        recv(1'b0, d);
        bus_stop;
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
        logic ack;
        set_addr(a, "R4");
        send(d, ack); chk("R4 data ack", 16'(ack), 16'd1);
        bus_stop;
        tick(WRC + 40);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R13 oe after reset", 16'(sda_oe), 16'd0);
        rand_read(16'h0000, d);
        chk("R13 erased byte", 16'(d), 16'h00FF);
    endtask

    task automatic t_addr;
        logic ack;
        bus_start;
        send(DEVW, ack); chk("R1 matching device ack", 16'(ack), 16'd1);
        bus_stop;
        bus_start;
        send(8'hBA, ack); chk("R1 wrong prefix nack", 16'(ack), 16'd0);
        bus_stop;
        bus_start;
        send(8'hA0, ack); chk("R2 strap mismatch nack", 16'(ack), 16'd0);
        send(DEVW, ack);  chk("R2 ignored until start", 16'(ack), 16'd0);
        bus_stop;
    endtask

    task automatic t_byte_write;
        logic ack;
        logic [7:0] d;
        set_addr(16'h1234, "R4");
        send(8'h3C, ack); chk("R4 data ack", 16'(ack), 16'd1);
        bus_stop;
        bus_start;
        send(DEVW, ack); chk("R9 nack while busy", 16'(ack), 16'd0);
        bus_stop;
        tick(WRC + 40);
        bus_start;
        send(DEVW, ack); chk("R9 ack after window", 16'(ack), 16'd1);
        bus_stop;
        rand_read(16'h1234, d);
        chk("R4 R5 read back", 16'(d), 16'h003C);
    endtask

    task automatic t_page;
        logic ack;
        logic [7:0] d;
        logic [7:0] exp [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        set_addr(16'h0205, "R6");
        for (int i = 0; i < 4; i++) begin
            send(exp[i], ack); chk("R6 page byte ack", 16'(ack), 16'd1);
        end
        bus_stop;
        tick(WRC + 40);
        set_addr(16'h0205, "R10");
        bus_start;
        send(DEVR, ack); chk("R10 read ack", 16'(ack), 16'd1);
        for (int i = 0; i < 4; i++) begin
            recv(i != 3, d);
            chk("R6 R10 sequential byte", 16'(d), 16'(exp[i]));
        end
        bus_stop;
    endtask

    task automatic t_wrap;
        logic ack;
        logic [7:0] d;
        set_addr(16'h037E, "R7");
        send(8'hA1, ack); send(8'hA2, ack); send(8'hA3, ack);
        chk("R7 third byte ack", 16'(ack), 16'd1);
        bus_stop;
        tick(WRC + 40);
        rand_read(16'h0300, d);
        chk("R7 wrapped to page start", 16'(d), 16'h00A3);
        rand_read(16'h037F, d);
        chk("R7 last page offset", 16'(d), 16'h00A2);
    endtask

    task automatic t_wp;
        logic ack;
        logic [7:0] d;
        wp = 1'b1;
        set_addr(16'h0150, "R8");
        send(8'h77, ack);
        bus_stop;
        wp = 1'b0;
        bus_start;
        send(DEVW, ack); chk("R8 no busy window", 16'(ack), 16'd1);
        bus_stop;
        rand_read(16'h0150, d);
        chk("R8 array unchanged", 16'(d), 16'h00FF);
    endtask

    task automatic t_cur;
        logic ack;
        logic [7:0] d;
        rand_read(16'h0205, d);
        chk("R11 first byte", 16'(d), 16'h0011);
        bus_start;
        send(DEVR, ack); chk("R11 current read ack", 16'(ack), 16'd1);
        recv(1'b0, d);
        bus_stop;
        chk("R11 current address plus one", 16'(d), 16'h0022);
    endtask

    task automatic t_roll;
        logic ack;
        logic [7:0] d;
        wr_byte(16'hFFFF, 8'hE1);
        wr_byte(16'h0000, 8'h0E);
        set_addr(16'hFFFF, "R10");
        bus_start;
        send(DEVR, ack);
        recv(1'b1, d); chk("R10 byte at top", 16'(d), 16'h00E1);
        recv(1'b0, d); chk("R10 rollover to zero", 16'(d), 16'h000E);
        bus_stop;
        bus_start;
        send(DEVR, ack);
        recv(1'b0, d);
        bus_stop;
        chk("R11 counter after rollover", 16'(d), 16'h00FF);
    endtask

    task automatic t_rstart;
        logic ack;
        logic [7:0] d;
        set_addr(16'h0088, "R12");
        send(8'h5A, ack);
        set_addr(16'h0088, "R3");
        bus_start;
        send(DEVR, ack);
        recv(1'b0, d);
        bus_stop;
        chk("R12 discarded data", 16'(d), 16'h00FF);
        bus_start;
        send(DEVW, ack); chk("R12 no busy window", 16'(ack), 16'd1);
        bus_stop;
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset;
        t_addr;
        t_byte_write;
        t_page;
        t_wrap;
        t_wp;
        t_cur;
        t_roll;
        t_rstart;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog (all): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule